// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a three-wire-plus-direction serial link. A host reaches a small bank of 12-bit registers through it. The host pulls the frame strobe low and clocks in a 4-bit register address, most significant bit first. It then either keeps the direction pin low and clocks in 12 data bits to write, or raises the direction pin and clocks the addressed register's contents back out on the same data line. The port drives the output-enable of the external data pad.

All pins are oversampled by the system clock through a synchronizer. Shifting happens on detected rising edges of the shift clock. A write reaches the register bank only on the sixteenth rising edge of a frame, so a frame cut short leaves the bank untouched. A parameter mask marks some addresses as read-only. These addresses return live values from an input bus and ignore writes. The serial link has no way to stall, so the bank's write and read paths take one word per frame with no back-pressure.

Top module: `sp_serial_port`

## Requirements
- R1: A frame is 16 rising shift-clock edges while the strobe is low. The first 4 bits carry the register address and the last 12 carry data. Both fields are sent most significant bit first.
- R2: On the 16th rising edge, with the direction pin low, the 12 data bits are written to the addressed writable register. No register changes at any other time.
- R3: If the strobe goes high before the 16th rising edge, the frame is dropped and every register keeps its value.
- R4: In a read, the addressed register is captured after the 4th address bit. Its bit 11 is on `sdio_o` before the 5th rising edge. Each later rising edge moves the next lower bit onto the line.
- R5: `sdio_oe` is high only while the strobe is low and the direction pin is high. It drops at once, with no clock, when the strobe rises or the direction pin falls.
- R6: Addresses whose bit is set in `RO_MASK` (by default addresses 12 to 15) read back their 12-bit slice of `ro_data_i`. A write to such an address changes nothing, and its slice of `reg_q_o` stays 0.
- R7: After reset, every writable register holds 0 and `sdio_oe` is low.
- R8: Rising edges after the 16th within the same frame are ignored. There is no second write and the stored value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host shift clock |
| sload_n | input | 1 | Frame strobe, active low |
| rw | input | 1 | Direction pin, high for read-back |
| sdio_i | input | 1 | Data line value from the pad |
| sdio_o | output | 1 | Read data to the pad |
| sdio_oe | output | 1 | Pad output enable |
| ro_data_i | input | 192 | Live values for read-only addresses, 12 bits per address, address 0 at the low end |
| reg_q_o | output | 192 | Contents of the writable registers, 12 bits per address, address 0 at the low end |

## Verification
The checker assumes that each level of `sclk`, `sload_n`, `rw` and `sdio_i` lasts several system clocks. This lets the synchronizer see every shift-clock phase and sample data that is already settled. It also assumes that the strobe goes high between frames for longer than the synchronizer delay. The bench holds each shift-clock phase for 10 system clocks and changes data and direction only while the shift clock is low. Between frames it leaves a gap of 40 system clocks with the strobe high.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_ADDR_W = 4;
  localparam int SP_DATA_W = 12;
  localparam int SP_SYNC_STAGES = 2;

  // Pin bundle carried through the synchronizer, idle values on reset
  typedef struct packed {
    logic sclk;
    logic sload_n;
    logic rw;
    logic sdi;
  } sp_pins_t;

  localparam sp_pins_t SP_PINS_IDLE = '{sclk: 1'b0, sload_n: 1'b1, rw: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/sp_pin_sync.sv
module sp_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_frame_ctrl.sv
module sp_frame_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sclk,
  input  logic              s_sload_n,
  input  logic              s_rw,
  input  logic              s_sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_load,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sclk_rise,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA0 = CNT_W'(ADDR_W);

  logic                sclk_q;
  logic [FRAME_W-2:0]  in_sr;
  logic [FRAME_W-1:0]  next_sr;
  logic [DATA_W-1:0]   out_sr;
  logic                take;

  assign sclk_rise = s_sclk & ~sclk_q;
  // a bit is accepted only inside a frame and only up to the frame length
  assign take      = sclk_rise & ~s_sload_n & (bit_cnt < CNT_FULL);
  assign next_sr   = {in_sr, s_sdi};

  assign rd_load = take & (bit_cnt == CNT_ADDR_LAST);
  assign rd_addr = next_sr[ADDR_W-1:0];

  assign wr_en   = take & (bit_cnt == CNT_LAST) & ~s_rw;
  assign wr_addr = next_sr[FRAME_W-1 -: ADDR_W];
  assign wr_data = next_sr[DATA_W-1:0];

  assign sdo = out_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
    end else begin
      sclk_q <= s_sclk;
      if (s_sload_n) begin
        bit_cnt <= '0;
        in_sr   <= '0;
      end else if (take) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        in_sr   <= next_sr[FRAME_W-2:0];
      end
      if (rd_load) begin
        out_sr <= rd_data;
      end else if (take && bit_cnt >= CNT_DATA0) begin
        out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 16'hF000,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_REGS*DATA_W-1:0] ro_data_i,
  output logic [NUM_REGS*DATA_W-1:0] reg_q_o
);
  logic [DATA_W-1:0] word [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (RO_MASK[g]) begin : g_ro
      assign word[g] = ro_data_i[g*DATA_W +: DATA_W];
      assign reg_q_o[g*DATA_W +: DATA_W] = '0;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      logic              unused_ro;
      assign unused_ro = ^ro_data_i[g*DATA_W +: DATA_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(g))   q <= wr_data;
      end
      assign word[g] = q;
      assign reg_q_o[g*DATA_W +: DATA_W] = q;
    end
  end

  assign rd_data = word[rd_addr];
endmodule

// File: rtl/sp_serial_port.sv
module sp_serial_port #(
  parameter int ADDR_W = sp_pkg::SP_ADDR_W,
  parameter int DATA_W = sp_pkg::SP_DATA_W,
  parameter int SYNC_STAGES = sp_pkg::SP_SYNC_STAGES,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 16'hF000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sclk,
  input  logic                              sload_n,
  input  logic                              rw,
  input  logic                              sdio_i,
  output logic                              sdio_o,
  output logic                              sdio_oe,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]     ro_data_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     reg_q_o
);
  import sp_pkg::*;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  sp_pins_t          pins_raw, pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              rd_load, wr_en, sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;

  assign pins_raw = '{sclk: sclk, sload_n: sload_n, rw: rw, sdi: sdio_i};

  sp_pin_sync #(
    .WIDTH  ($bits(sp_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SP_PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  sp_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_sclk   (pins_s.sclk),
    .s_sload_n(pins_s.sload_n),
    .s_rw     (pins_s.rw),
    .s_sdi    (pins_s.sdi),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .rd_load  (rd_load),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdio_o),
    .sclk_rise(sclk_rise),
    .bit_cnt  (bit_cnt)
  );

  sp_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ro_data_i(ro_data_i),
    .reg_q_o  (reg_q_o)
  );

  // pad direction follows the raw pins so release needs no clock
  assign sdio_oe = ~sload_n & rw;
endmodule

// File: rtl/sp_serial_port_chk.sv
module sp_serial_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 16'hF000,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sload_n,
  input logic                          rw,
  input logic                          sdio_oe,
  input logic [(1<<ADDR_W)*DATA_W-1:0] reg_q_o,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic                          rd_load,
  input logic [CNT_W-1:0]              bit_cnt,
  input logic                          s_sload_n
);
  // R5
  tri_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sload_n |-> !sdio_oe);
  // R5
  tri_on_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> !sdio_oe);
  // R2
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q_o) |-> $past(wr_en));
  // R6
  ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && RO_MASK[wr_addr]) |=> $stable(reg_q_o));
  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));
  // R3
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_sload_n |=> (bit_cnt == '0));
  // R4
  load_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (bit_cnt == CNT_W'(ADDR_W)));
  // R8
  no_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_W'(FRAME_W) && !s_sload_n) |=> (bit_cnt == CNT_W'(FRAME_W)));
endmodule

bind sp_serial_port sp_serial_port_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RO_MASK(RO_MASK)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sload_n  (sload_n),
  .rw       (rw),
  .sdio_oe  (sdio_oe),
  .reg_q_o  (reg_q_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_load  (rd_load),
  .bit_cnt  (bit_cnt),
  .s_sload_n(pins_s.sload_n)
);

// File: tb/sp_serial_port_tb_top.sv
module sp_serial_port_tb_top;
  localparam int HALF = 10;
  localparam int GAP = 40;
  localparam logic [15:0] RO_M = 16'hF000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sload_n = 1'b1, rw = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe;
  logic [191:0] ro_data_i, reg_q_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sp_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sload_n(sload_n), .rw(rw),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .ro_data_i(ro_data_i), .reg_q_o(reg_q_o)
  );

  function automatic logic [11:0] ro_val(int a);
    return 12'(a * 613 + 2748);
  endfunction

  function automatic logic [11:0] wr_val(int a, int pass);
    return 12'(a * 349 + 1234 + pass * 1877);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nclk rising edges; rd selects read-back after the address
  task automatic frame(input logic [3:0] a, input logic [11:0] d, input bit rd,
                       input int nclk, output logic [11:0] got);
    got = '0;
    sload_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      if (i < 4)       sdio_i = a[3-i];
      else if (rd)     rw = 1'b1;
      else if (i < 16) sdio_i = d[15-i];
      else             sdio_i = 1'b1;
      wait_n(HALF);
      if (rd && i >= 4 && i < 16) begin
        got[15-i] = sdio_o;
        if (i == 4) chk("R5 oe in read", 32'(sdio_oe), 32'd1);
      end
      sclk = 1'b1;
      wait_n(HALF);
    end
    sclk = 1'b0;
    wait_n(HALF);
    sload_n = 1'b1;
    #1;
    if (rd) chk("R5 release on strobe", 32'(sdio_oe), 32'd0);
    rw = 1'b0;
    wait_n(GAP);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) ro_data_i[a*12 +: 12] = ro_val(a);
    wait_n(4);
    chk("R7 reset regs", 32'(|reg_q_o), 32'd0);
    chk("R7 reset oe", 32'(sdio_oe), 32'd0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R7 regs after reset", 32'(|reg_q_o), 32'd0);
  end

  initial begin : main
    logic [11:0] got;
    wait (rst_n === 1'b1);
    wait_n(8);
    // R5 direction table over strobe and direction pin
    for (int c = 0; c < 4; c++) begin
      sload_n = c[1];
      rw = c[0];
      #1;
      chk("R5 direction", 32'(sdio_oe), 32'(!c[1] && c[0]));
      wait_n(2);
    end
    sload_n = 1'b1; rw = 1'b0;
    wait_n(GAP);
    // R5 immediate release when direction falls inside a frame
    sload_n = 1'b0; rw = 1'b1;
    #1 chk("R5 oe set", 32'(sdio_oe), 32'd1);
    rw = 1'b0;
    #1 chk("R5 release on direction", 32'(sdio_oe), 32'd0);
    sload_n = 1'b1;
    wait_n(GAP);

    // R1 R2 R4 R6 two passes over every address
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 16; a++) begin
        frame(4'(a), wr_val(a, pass), 1'b0, 16, got);
        if (RO_M[a]) chk("R6 ro slot untouched", 32'(reg_q_o[a*12 +: 12]), 32'd0);
        else         chk("R2 write commit", 32'(reg_q_o[a*12 +: 12]), 32'(wr_val(a, pass)));
      end
      for (int a = 0; a < 16; a++) begin
        frame(4'(a), 12'h000, 1'b1, 16, got);
        chk("R4 R1 read msb first", 32'(got), 32'(RO_M[a] ? ro_val(a) : wr_val(a, pass)));
      end
    end

    // R3 write cut short at 10 and at 15 edges
    frame(4'd3, 12'h5A5, 1'b0, 10, got);
    chk("R3 abort after 10", 32'(reg_q_o[3*12 +: 12]), 32'(wr_val(3, 1)));
    frame(4'd3, 12'h5A5, 1'b0, 15, got);
    chk("R3 abort after 15", 32'(reg_q_o[3*12 +: 12]), 32'(wr_val(3, 1)));
    frame(4'd3, 12'h000, 1'b1, 16, got);
    chk("R3 read after abort", 32'(got), 32'(wr_val(3, 1)));

    // R8 extra edges past the 16th
    frame(4'd5, 12'h0C3, 1'b0, 20, got);
    chk("R8 overlong write", 32'(reg_q_o[5*12 +: 12]), 32'h0C3);
    frame(4'd5, 12'h000, 1'b1, 16, got);
    chk("R8 read after overlong", 32'(got), 32'h0C3);

    // R2 no write during a read frame
    chk("R2 read leaves regs", 32'(reg_q_o[5*12 +: 12]), 32'h0C3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule